// File: doc/BRIEF.md
# Bridgeless Boost Gate Sequencer with Snubber Pre-Pulse

This block produces the gate timing for the two main switches of a bridgeless (totem-pole) boost stage, one fixed switching period at a time. The period is counted in clock ticks. With the default 250 MHz tick this is 625 ticks, or 2500 ns, which gives a 400 kHz switching rate. Which switch leads and which freewheels depends on a polarity flag that follows the sign of the line half-wave. Before the leading switch turns on, its active snubber is driven for a per-cycle width. The block then takes that width out of the requested duty, so the duty seen by the converter stays as requested.

Every period runs a fixed order of steps. The freewheel switch turns off at the start of the period. After the first dead time the snubber pulse runs. After the second dead time the leading switch's main pulse runs. After the third dead time the freewheel switch turns back on until the period ends. Any step that would run past the period end is cut off there. All settings are captured at the last tick of a period and apply to the whole of the next one. An overcurrent input ends the leading switch's pulses in the same tick it is seen, and keeps them off until the next period begins. Working out the duty and measuring currents or voltages are left to the surrounding logic.

Top module: `bridgeless_pwm`

## Requirements
- R1: While reset is asserted, and for the whole first period after reset is released, all four outputs are low.
- R2: A period lasts PERIOD ticks. The duty, snubber width, dead times and polarity are captured only in the last tick of a period and take effect from the first tick of the next. A change on these inputs at any other time leaves the outputs of the current period unchanged.
- R3: When pol_neg is 0, switch 2 leads and switch 1 freewheels. When pol_neg is 1, the roles swap. The snubber output of the freewheeling switch stays low throughout.
- R4: Let dt_pre be A, the snubber width S, dt_mid B, the duty D, dt_post C, and M = D − S. At tick t of a period, the leading snubber is high for A ≤ t < A+S and the leading gate is high for A+S+B ≤ t < A+S+B+M. The freewheel gate is high for t ≥ A+S+B+M+C. At all other ticks all outputs are low.
- R5: In a period without overcurrent, the leading gate is high for exactly D − S ticks, limited by the ticks left before the period ends. A zero snubber width gives no snubber pulse, and the gate then starts at tick A+B.
- R6: When D ≤ S, neither the snubber pulse nor the main pulse is issued in that period, and the freewheel gate turns on at tick A+B+C.
- R7: In any tick where oc_trip is high, the leading switch's gate and snubber are low. From the next tick they stay low until the period ends. The freewheel gate keeps its scheduled timing.
- R8: The two main gates are never high in the same tick, and no snubber output is high together with its own switch's gate.
- R9: Steps that reach the period end are cut off at the boundary. When A+S+B+M+C ≥ PERIOD, the freewheel gate stays low for that whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cnt | input | CNT_W | Requested duty in ticks, including the snubber time |
| snub_cnt | input | SNUB_W | Snubber pre-pulse width in ticks |
| dt_pre | input | DT_W | Dead time from freewheel-off to snubber-on |
| dt_mid | input | DT_W | Dead time from snubber-off to main-on |
| dt_post | input | DT_W | Dead time from main-off to freewheel-on |
| pol_neg | input | 1 | 0: switch 2 leads; 1: switch 1 leads |
| oc_trip | input | 1 | Cycle-by-cycle overcurrent trip |
| sw1_gate | output | 1 | Main gate drive, switch 1 |
| sw2_gate | output | 1 | Main gate drive, switch 2 |
| sw1_snub | output | 1 | Snubber drive, switch 1 |
| sw2_snub | output | 1 | Snubber drive, switch 2 |

## Verification
The sequence is tried with both polarities under one set of settings, which shows whether the roles swap without moving any edge. It is also run with a zero snubber width, with a duty equal to and below the snubber width, and with all dead times at zero. These cases separate the subtraction, the skip rule and the edge arithmetic from one another. A duty long enough to cross the period end checks the cut-off and the missing freewheel interval. Trips placed during the main pulse and during the snubber pulse show the same-tick shutdown and the hold until the period ends. The settings are changed in the middle of every period to show that they are captured only at the boundary.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;

  localparam int EDGE_W = 16;

  typedef struct packed {
    logic [EDGE_W-1:0] snub_on;
    logic [EDGE_W-1:0] snub_off;
    logic [EDGE_W-1:0] main_on;
    logic [EDGE_W-1:0] main_off;
    logic [EDGE_W-1:0] fw_on;
  } edges_t;

  // Turns one period's settings into absolute tick edges.
  // When the duty does not exceed the snubber width, both pulses are dropped.
  function automatic edges_t plan_edges(input int unsigned pre_dt,
                                        input int unsigned snub,
                                        input int unsigned mid_dt,
                                        input int unsigned duty,
                                        input int unsigned post_dt);
    int unsigned sn;
    int unsigned on_w;
    edges_t e;
    if (duty > snub) begin
      sn   = snub;
      on_w = duty - snub;
    end else begin
      sn   = 0;
      on_w = 0;
    end
    e.snub_on  = EDGE_W'(pre_dt);
    e.snub_off = EDGE_W'(pre_dt + sn);
    e.main_on  = EDGE_W'(pre_dt + sn + mid_dt);
    e.main_off = EDGE_W'(pre_dt + sn + mid_dt + on_w);
    e.fw_on    = EDGE_W'(pre_dt + sn + mid_dt + on_w + post_dt);
    return e;
  endfunction

  // Half-open window test: lo <= t < hi
  function automatic logic in_window(input logic [EDGE_W-1:0] t,
                                     input logic [EDGE_W-1:0] lo,
                                     input logic [EDGE_W-1:0] hi);
    return (t >= lo) && (t < hi);
  endfunction

endpackage

// File: rtl/bpwm_period_timer.sv
module bpwm_period_timer #(
  parameter int PERIOD = 625,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] tick,
  output logic             wrap,
  output logic             armed
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  assign wrap = (tick == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick  <= '0;
      armed <= 1'b0;
    end else if (wrap) begin
      tick  <= '0;
      armed <= 1'b1;
    end else begin
      tick  <= tick + 1'b1;
    end
  end
endmodule

// File: rtl/bpwm_setting_latch.sv
module bpwm_setting_latch
  import bpwm_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int SNUB_W = 7,
  parameter int DT_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrap,
  input  logic [CNT_W-1:0]  duty_cnt,
  input  logic [SNUB_W-1:0] snub_cnt,
  input  logic [DT_W-1:0]   dt_pre,
  input  logic [DT_W-1:0]   dt_mid,
  input  logic [DT_W-1:0]   dt_post,
  input  logic              pol_neg,
  output edges_t            edges,
  output logic              pol_q
);
  edges_t next_edges;

  assign next_edges = plan_edges(32'(dt_pre), 32'(snub_cnt), 32'(dt_mid),
                                 32'(duty_cnt), 32'(dt_post));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges <= '0;
      pol_q <= 1'b0;
    end else if (wrap) begin
      edges <= next_edges;
      pol_q <= pol_neg;
    end
  end
endmodule

// File: rtl/bpwm_phase_decode.sv
module bpwm_phase_decode
  import bpwm_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] tick,
  input  edges_t           edges,
  output logic             snub_win,
  output logic             main_win,
  output logic             fw_win
);
  logic [EDGE_W-1:0] t_ext;

  assign t_ext    = EDGE_W'(tick);
  assign snub_win = in_window(t_ext, edges.snub_on, edges.snub_off);
  assign main_win = in_window(t_ext, edges.main_on, edges.main_off);
  assign fw_win   = (t_ext >= edges.fw_on);
endmodule

// File: rtl/bpwm_trip_guard.sv
module bpwm_trip_guard (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_trip,
  input  logic wrap,
  output logic trip_hold,
  output logic lead_block
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    trip_hold <= 1'b0;
    else if (wrap) trip_hold <= 1'b0;
    else           trip_hold <= trip_hold | oc_trip;
  end

  assign lead_block = oc_trip | trip_hold;
endmodule

// File: rtl/bridgeless_pwm.sv
module bridgeless_pwm
  import bpwm_pkg::*;
#(
  parameter int PERIOD = 625,
  parameter int SNUB_W = 7,
  parameter int DT_W   = 6,
  localparam int CNT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  duty_cnt,
  input  logic [SNUB_W-1:0] snub_cnt,
  input  logic [DT_W-1:0]   dt_pre,
  input  logic [DT_W-1:0]   dt_mid,
  input  logic [DT_W-1:0]   dt_post,
  input  logic              pol_neg,
  input  logic              oc_trip,
  output logic              sw1_gate,
  output logic              sw2_gate,
  output logic              sw1_snub,
  output logic              sw2_snub
);
  logic [CNT_W-1:0] tick;
  logic             wrap;
  logic             armed;
  edges_t           edges;
  logic             pol_q;
  logic             snub_win, main_win, fw_win;
  logic             trip_hold, lead_block;
  logic             lead_is_sw2;
  logic [1:0]       gate_v, snub_v;

  bpwm_period_timer #(.PERIOD(PERIOD)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .armed(armed)
  );

  bpwm_setting_latch #(.CNT_W(CNT_W), .SNUB_W(SNUB_W), .DT_W(DT_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .wrap(wrap),
    .duty_cnt(duty_cnt), .snub_cnt(snub_cnt),
    .dt_pre(dt_pre), .dt_mid(dt_mid), .dt_post(dt_post),
    .pol_neg(pol_neg), .edges(edges), .pol_q(pol_q)
  );

  bpwm_phase_decode #(.CNT_W(CNT_W)) u_decode (
    .tick(tick), .edges(edges),
    .snub_win(snub_win), .main_win(main_win), .fw_win(fw_win)
  );

  bpwm_trip_guard u_trip (
    .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip), .wrap(wrap),
    .trip_hold(trip_hold), .lead_block(lead_block)
  );

  assign lead_is_sw2 = ~pol_q;

  // Index 0 is switch 1, index 1 is switch 2
  for (genvar i = 0; i < 2; i++) begin : g_sw
    logic is_lead;
    assign is_lead   = (i == 1) ? lead_is_sw2 : ~lead_is_sw2;
    assign gate_v[i] = armed & (is_lead ? (main_win & ~lead_block) : fw_win);
    assign snub_v[i] = armed & is_lead & snub_win & ~lead_block;
  end

  assign sw1_gate = gate_v[0];
  assign sw2_gate = gate_v[1];
  assign sw1_snub = snub_v[0];
  assign sw2_snub = snub_v[1];
endmodule

// File: rtl/bpwm_chk.sv
module bpwm_chk (
  input logic clk,
  input logic rst_n,
  input logic oc_trip,
  input logic wrap,
  input logic armed,
  input logic lead_is_sw2,
  input logic trip_hold,
  input logic sw1_gate,
  input logic sw2_gate,
  input logic sw1_snub,
  input logic sw2_snub
);
  logic lead_any;
  assign lead_any = lead_is_sw2 ? (sw2_gate | sw2_snub) : (sw1_gate | sw1_snub);

  a_r8_mains_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw1_gate && sw2_gate));

  a_r8_snub_not_with_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw1_snub && sw1_gate) && !(sw2_snub && sw2_gate));

  a_r3_idle_snub_low: assert property (@(posedge clk) disable iff (!rst_n)
    lead_is_sw2 ? !sw1_snub : !sw2_snub);

  a_r7_trip_blocks_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip || trip_hold) |-> !lead_any);

  a_r7_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_trip && !wrap) |=> trip_hold);

  a_r1_idle_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !(sw1_gate || sw2_gate || sw1_snub || sw2_snub));

  a_r2_roles_change_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(lead_is_sw2));
endmodule

bind bridgeless_pwm bpwm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .oc_trip(oc_trip), .wrap(wrap), .armed(armed),
  .lead_is_sw2(lead_is_sw2), .trip_hold(trip_hold),
  .sw1_gate(sw1_gate), .sw2_gate(sw2_gate),
  .sw1_snub(sw1_snub), .sw2_snub(sw2_snub)
);

// File: tb/sim_bridgeless_pwm.sv
`timescale 1ns/100ps
module sim_bridgeless_pwm;
  localparam int P = 625;
  localparam int SNUB_W = 7;
  localparam int DT_W = 6;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CNT_W-1:0]  duty_cnt = '0;
  logic [SNUB_W-1:0] snub_cnt = '0;
  logic [DT_W-1:0]   dt_pre = '0, dt_mid = '0, dt_post = '0;
  logic pol_neg = 1'b0, fault = 1'b0;
  logic sw1_gate, sw2_gate, sw1_snub, sw2_snub;

  always #2.5 clk = ~clk;

  bridgeless_pwm #(.PERIOD(P), .SNUB_W(SNUB_W), .DT_W(DT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .duty_cnt(duty_cnt), .snub_cnt(snub_cnt),
    .dt_pre(dt_pre), .dt_mid(dt_mid), .dt_post(dt_post), .pol_neg(pol_neg),
    .oc_trip(fault), .sw1_gate(sw1_gate), .sw2_gate(sw2_gate),
    .sw1_snub(sw1_snub), .sw2_snub(sw2_snub)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t sbq[$];

  // Reference state, advanced from the requirements
  int m_cnt = 0;
  bit m_live = 0, m_armed = 0, m_hold = 0;
  int L_A = 0, L_S = 0, L_B = 0, L_D = 0, L_C = 0;
  bit L_pol = 0;

  always @(posedge clk) if (m_live) begin
    if (m_cnt == P-1) begin
      L_A = dt_pre; L_S = snub_cnt; L_B = dt_mid; L_D = duty_cnt; L_C = dt_post;
      L_pol = pol_neg; m_armed = 1; m_hold = 0; m_cnt = 0;
    end else begin
      m_hold = m_hold | fault;
      m_cnt++;
    end
  end

  function automatic int snub_eff();  return (L_D > L_S) ? L_S : 0;       endfunction
  function automatic int main_eff();  return (L_D > L_S) ? L_D - L_S : 0; endfunction

  // bits: {sw2_snub, sw1_snub, sw2_gate, sw1_gate}
  function automatic logic [3:0] expect_now();
    int s0, s1, m0, m1, f0;
    bit sn, mn, fw, blk;
    if (!m_armed) return 4'b0000;
    s0 = L_A; s1 = s0 + snub_eff(); m0 = s1 + L_B; m1 = m0 + main_eff(); f0 = m1 + L_C;
    sn = (m_cnt >= s0) && (m_cnt < s1);
    mn = (m_cnt >= m0) && (m_cnt < m1);
    fw = (m_cnt >= f0);
    blk = fault || m_hold;
    if (L_pol) return {1'b0, sn & !blk, fw, mn & !blk};
    else       return {sn & !blk, 1'b0, mn & !blk, fw};
  endfunction

  function automatic string tag_now();
    if (!m_armed) return "R1";
    if (int'(duty_cnt) != L_D || int'(snub_cnt) != L_S || int'(dt_pre) != L_A ||
        int'(dt_mid) != L_B || int'(dt_post) != L_C || pol_neg != L_pol) return "R2";
    if (fault || m_hold) return "R7";
    if (L_D <= L_S) return "R6";
    if (L_pol) return "R3";
    return "R4";
  endfunction

  // Driver side of the scoreboard: one expected item per tick
  always @(negedge clk) if (m_live && !done) begin
    item_t it;
    it.exp = expect_now();
    it.tag = tag_now();
    sbq.push_back(it);
  end

  int main_ticks = 0, fw_ticks = 0;
  bit per_fault = 0;

  // Monitor side
  always @(negedge clk) if (m_live && !done) begin
    item_t it;
    logic [3:0] act;
    int exp_main, exp_fw, m0, f0;
    #0.2;
    it = sbq.pop_front();
    act = {sw2_snub, sw1_snub, sw2_gate, sw1_gate};
    checks++;
    if (act !== it.exp) begin
      errors++;
      $display("FAIL %s tick %0d: outputs %b expected %b", it.tag, m_cnt, act, it.exp);
    end
    checks++;
    if (sw1_gate && sw2_gate) begin  // R8
      errors++;
      $display("FAIL R8 tick %0d: both gates high, actual 11 expected not 11", m_cnt);
    end
    if (m_armed) begin
      if (L_pol ? sw1_gate : sw2_gate) main_ticks++;
      if (L_pol ? sw2_gate : sw1_gate) fw_ticks++;
      if (fault || m_hold) per_fault = 1;
      if (m_cnt == P-1) begin
        m0 = L_A + snub_eff() + L_B;
        f0 = m0 + main_eff() + L_C;
        exp_main = (P - m0 < main_eff()) ? P - m0 : main_eff();
        if (exp_main < 0) exp_main = 0;
        exp_fw = (f0 >= P) ? 0 : P - f0;
        if (!per_fault) begin
          checks++;
          if (main_ticks != exp_main) begin  // R5
            errors++;
            $display("FAIL R5: main on-ticks %0d expected %0d", main_ticks, exp_main);
          end
          checks++;
          if (fw_ticks != exp_fw) begin  // R9
            errors++;
            $display("FAIL R9: freewheel ticks %0d expected %0d", fw_ticks, exp_fw);
          end
        end
        main_ticks = 0; fw_ticks = 0; per_fault = 0;
      end
    end
  end

  task automatic run_period(input int a, input int s, input int b, input int d,
                            input int c, input bit pol, input int f_at, input int f_len);
    do @(negedge clk); while (m_cnt != 99);
    @(posedge clk); #1;
    dt_pre = DT_W'(a); snub_cnt = SNUB_W'(s); dt_mid = DT_W'(b);
    duty_cnt = CNT_W'(d); dt_post = DT_W'(c); pol_neg = pol;
    if (f_at > 0) begin
      do @(negedge clk); while (m_cnt != P-1);
      do @(negedge clk); while (m_cnt != f_at-1);
      @(posedge clk); #1 fault = 1'b1;
      repeat (f_len) @(posedge clk);
      #1 fault = 1'b0;
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); #0.5;
    checks++;
    if ({sw2_snub, sw1_snub, sw2_gate, sw1_gate} !== 4'b0000) begin  // R1 reset state
      errors++;
      $display("FAIL R1 in reset: outputs %b expected 0000",
               {sw2_snub, sw1_snub, sw2_gate, sw1_gate});
    end
    rst_n = 1'b1; m_live = 1;
    run_period(5, 40, 4, 300, 6, 0, 0, 0);    // R4 positive half-wave
    run_period(5, 40, 4, 300, 6, 1, 0, 0);    // R3 swapped roles
    run_period(3, 0, 3, 200, 3, 0, 0, 0);     // R5 zero snubber width
    run_period(4, 40, 4, 30, 5, 1, 0, 0);     // R6 duty below snubber
    run_period(4, 40, 4, 40, 5, 0, 0, 0);     // R6 duty equal to snubber
    run_period(20, 30, 10, 600, 10, 0, 0, 0); // R9 cut at period end
    run_period(0, 10, 0, 100, 0, 1, 0, 0);    // R4 zero dead times
    run_period(5, 40, 4, 300, 6, 0, 150, 3);  // R7 trip during main pulse
    run_period(5, 40, 4, 300, 6, 1, 20, 1);   // R7 trip during snubber
    run_period(8, 20, 8, 400, 8, 0, 0, 0);    // R2 settings after trips
    repeat (2*P + 5) @(posedge clk);
    @(negedge clk); #1;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not end, actual running expected finished");
      summary();
      $finish;
    end
  end
endmodule